// File: doc/BRIEF.md
# Slotted Packet Concentrator with Loser Recirculation

This block gathers packets from N input ports and forwards at most L of them per time slot, one per output lane. A slot is marked by a one-cycle strobe; on that cycle every valid packet on the inputs, together with any packet held back from the previous slot, contends for the outputs. The winners leave on registered output lanes in the cycle after the strobe. Lanes are filled from lane 0 upward, and no two winners share a lane.

Packets that lose are not all thrown away. Up to W first-time losers are parked in internal wraparound registers and take part in the next slot ahead of new arrivals. This needs no extra ports. A parked packet that loses again is dropped, so each packet gets at most two tries. Every other loser is dropped. The number dropped in a slot is reported as a one-cycle pulse with a count, and a saturating running total is kept.

Top module: `kc_concentrator`

## Requirements
- R1: Output lanes carry valid packets only in the cycle right after a cycle with `slot_i` high. In every other cycle `out_valid_o` is all zero.
- R2: A slot delivers min(L, candidates) packets. The valid lanes are always a contiguous group starting at lane 0, with one packet per lane.
- R3: The order of candidates is fixed. Parked packets come first, in ascending path order, then new inputs in ascending port order. Lane k carries the k-th candidate in that order.
- R4: After the winners are taken, up to W of the losers that arrived new in this slot are parked, lowest port first. They compete in the next slot.
- R5: A parked packet that fails to win in its second slot is dropped. It is never parked again.
- R6: In the cycle after a slot, `drop_pulse_o` is high exactly when at least one packet was dropped. `drop_slot_o` then gives the number dropped, which is candidates minus winners minus newly parked. Outside that cycle both are zero.
- R7: `drop_total_o` grows by each slot's drop count and saturates at its all-ones value. It never decreases except on reset.
- R8: Reset clears the parked packets, the total, the pulse and all output valids.
- R9: Input valids and data have no effect in cycles where `slot_i` is low.
- R10: Parked packets stay parked through any number of idle cycles until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_i | input | 1 | Slot strobe; contention happens in this cycle |
| in_valid_i | input | N | Per-port packet present |
| in_data_i | input | N*DW | Payloads, port p at bits p*DW +: DW |
| out_valid_o | output | L | Per-lane winner present |
| out_data_o | output | L*DW | Winner payloads, lane k at bits k*DW +: DW |
| drop_pulse_o | output | 1 | Packets were dropped in the last slot |
| drop_slot_o | output | clog2(N+W+1) | Number dropped in the last slot |
| drop_total_o | output | DROP_W | Saturating count of all dropped packets |

## Verification
A wrong parked packet stays hidden at first and only shows up one slot later. It appears at the ports as an extra, missing or wrongly ordered payload on the low lanes, or as a drop count off by the size of the error. The bench therefore runs sequences where the held packets must outlast idle cycles and then win, or lose and be dropped, in the following slot. The reference model compares every lane and every counter in every cycle, so a fault surfaces no later than the cycle after the second slot.

// File: rtl/kc_pkg.sv
package kc_pkg;
  typedef enum logic {
    SRC_NEW  = 1'b0,
    SRC_WRAP = 1'b1
  } kc_src_e;
endpackage

// File: rtl/kc_select.sv
module kc_select
  import kc_pkg::*;
#(
  parameter int N  = 8,
  parameter int L  = 4,
  parameter int W  = 2,
  parameter int DW = 16,
  localparam int M     = W + N,
  localparam int CNT_W = $clog2(N + W + 1)
) (
  input  logic [M-1:0]      cand_v,
  input  logic [M*DW-1:0]   cand_d,
  input  kc_src_e           cand_src [M],
  output logic [L-1:0]      win_v,
  output logic [L*DW-1:0]   win_d,
  output logic [W-1:0]      keep_v,
  output logic [W*DW-1:0]   keep_d,
  output logic [CNT_W-1:0]  drop_n
);
  always_comb begin
    int nwin;
    int nkeep;
    win_v  = '0;
    win_d  = '0;
    keep_v = '0;
    keep_d = '0;
    drop_n = '0;
    nwin   = 0;
    nkeep  = 0;
    for (int m = 0; m < M; m++) begin
      if (cand_v[m]) begin
        if (nwin < L) begin
          for (int k = 0; k < L; k++) begin
            if (k == nwin) begin
              win_v[k]           = 1'b1;
              win_d[k*DW +: DW]  = cand_d[m*DW +: DW];
            end
          end
          nwin = nwin + 1;
        end else if (cand_src[m] == SRC_NEW && nkeep < W) begin
          for (int j = 0; j < W; j++) begin
            if (j == nkeep) begin
              keep_v[j]          = 1'b1;
              keep_d[j*DW +: DW] = cand_d[m*DW +: DW];
            end
          end
          nkeep = nkeep + 1;
        end else begin
          drop_n = drop_n + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kc_wrap_store.sv
module kc_wrap_store #(
  parameter int W  = 2,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [W-1:0]    keep_v,
  input  logic [W*DW-1:0] keep_d,
  output logic [W-1:0]    held_v,
  output logic [W*DW-1:0] held_d
);
  for (genvar g = 0; g < W; g++) begin : g_path
    logic          v_q;
    logic [DW-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (load) begin
        v_q <= keep_v[g];
      end
    end
    always_ff @(posedge clk) begin
      if (load) d_q <= keep_d[g*DW +: DW];
    end
    assign held_v[g]           = v_q;
    assign held_d[g*DW +: DW]  = d_q;
  end
endmodule

// File: rtl/kc_out_stage.sv
module kc_out_stage #(
  parameter int L  = 4,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [L-1:0]    win_v,
  input  logic [L*DW-1:0] win_d,
  output logic [L-1:0]    lane_v,
  output logic [L*DW-1:0] lane_d
);
  for (genvar g = 0; g < L; g++) begin : g_lane
    logic          v_q;
    logic [DW-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= load & win_v[g];
    end
    always_ff @(posedge clk) begin
      if (load) d_q <= win_d[g*DW +: DW];
    end
    assign lane_v[g]          = v_q;
    assign lane_d[g*DW +: DW] = d_q;
  end
endmodule

// File: rtl/kc_drop_tally.sv
module kc_drop_tally #(
  parameter int CNT_W  = 4,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CNT_W-1:0]  drop_n,
  output logic              pulse,
  output logic [CNT_W-1:0]  slot_cnt,
  output logic [DROP_W-1:0] total
);
  localparam int SUM_W = (DROP_W > CNT_W ? DROP_W : CNT_W) + 1;
  localparam logic [SUM_W-1:0] TOP = SUM_W'({DROP_W{1'b1}});

  logic [SUM_W-1:0] sum;
  assign sum = SUM_W'(total) + SUM_W'(drop_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse    <= 1'b0;
      slot_cnt <= '0;
      total    <= '0;
    end else if (load && drop_n != '0) begin
      pulse    <= 1'b1;
      slot_cnt <= drop_n;
      total    <= (sum > TOP) ? {DROP_W{1'b1}} : sum[DROP_W-1:0];
    end else begin
      pulse    <= 1'b0;
      slot_cnt <= '0;
    end
  end
endmodule

// File: rtl/kc_concentrator.sv
module kc_concentrator
  import kc_pkg::*;
#(
  parameter int N      = 8,
  parameter int L      = 4,
  parameter int W      = 2,
  parameter int DW     = 16,
  parameter int DROP_W = 16,
  localparam int M     = W + N,
  localparam int CNT_W = $clog2(N + W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [N-1:0]      in_valid_i,
  input  logic [N*DW-1:0]   in_data_i,
  output logic [L-1:0]      out_valid_o,
  output logic [L*DW-1:0]   out_data_o,
  output logic              drop_pulse_o,
  output logic [CNT_W-1:0]  drop_slot_o,
  output logic [DROP_W-1:0] drop_total_o
);
  logic [W-1:0]      held_v;
  logic [W*DW-1:0]   held_d;
  logic [M-1:0]      cand_v;
  logic [M*DW-1:0]   cand_d;
  kc_src_e           cand_src [M];
  logic [L-1:0]      win_v;
  logic [L*DW-1:0]   win_d;
  logic [W-1:0]      keep_v;
  logic [W*DW-1:0]   keep_d;
  logic [CNT_W-1:0]  drop_n;

  // parked packets occupy the low candidate slots, so they rank first
  for (genvar g = 0; g < M; g++) begin : g_cand
    if (g < W) begin : g_wrap
      assign cand_v[g]          = held_v[g];
      assign cand_d[g*DW +: DW] = held_d[g*DW +: DW];
      assign cand_src[g]        = SRC_WRAP;
    end else begin : g_new
      assign cand_v[g]          = in_valid_i[g-W];
      assign cand_d[g*DW +: DW] = in_data_i[(g-W)*DW +: DW];
      assign cand_src[g]        = SRC_NEW;
    end
  end

  kc_select #(.N(N), .L(L), .W(W), .DW(DW)) u_select (
    .cand_v   (cand_v),
    .cand_d   (cand_d),
    .cand_src (cand_src),
    .win_v    (win_v),
    .win_d    (win_d),
    .keep_v   (keep_v),
    .keep_d   (keep_d),
    .drop_n   (drop_n)
  );

  kc_wrap_store #(.W(W), .DW(DW)) u_wrap (
    .clk    (clk),
    .rst    (rst),
    .load   (slot_i),
    .keep_v (keep_v),
    .keep_d (keep_d),
    .held_v (held_v),
    .held_d (held_d)
  );

  kc_out_stage #(.L(L), .DW(DW)) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (slot_i),
    .win_v  (win_v),
    .win_d  (win_d),
    .lane_v (out_valid_o),
    .lane_d (out_data_o)
  );

  kc_drop_tally #(.CNT_W(CNT_W), .DROP_W(DROP_W)) u_tally (
    .clk      (clk),
    .rst      (rst),
    .load     (slot_i),
    .drop_n   (drop_n),
    .pulse    (drop_pulse_o),
    .slot_cnt (drop_slot_o),
    .total    (drop_total_o)
  );
endmodule

// File: rtl/kc_concentrator_chk.sv
module kc_concentrator_chk #(
  parameter int L      = 4,
  parameter int CNT_W  = 4,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_i,
  input logic [L-1:0]      out_valid_o,
  input logic              drop_pulse_o,
  input logic [CNT_W-1:0]  drop_slot_o,
  input logic [DROP_W-1:0] drop_total_o
);
  localparam logic [DROP_W:0] TOP = {1'b0, {DROP_W{1'b1}}};

  // R1
  lanes_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_i) |-> out_valid_o == '0);

  // R2
  lanes_packed_chk: assert property (@(posedge clk) disable iff (rst)
    ((out_valid_o + L'(1)) & out_valid_o) == '0);

  // R6
  pulse_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
    drop_pulse_o |-> $past(slot_i) && drop_slot_o != '0);

  // R6
  count_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !drop_pulse_o |-> drop_slot_o == '0);

  // R7
  total_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !drop_pulse_o |-> $stable(drop_total_o));

  // R7
  total_add_chk: assert property (@(posedge clk) disable iff (rst)
    drop_pulse_o |-> {1'b0, drop_total_o} ==
      (({1'b0, $past(drop_total_o)} + (DROP_W+1)'(drop_slot_o)) > TOP ? TOP
        : ({1'b0, $past(drop_total_o)} + (DROP_W+1)'(drop_slot_o))));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> out_valid_o == '0 && drop_total_o == '0 && !drop_pulse_o);
endmodule

bind kc_concentrator kc_concentrator_chk #(.L(L), .CNT_W(CNT_W), .DROP_W(DROP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_i       (slot_i),
  .out_valid_o  (out_valid_o),
  .drop_pulse_o (drop_pulse_o),
  .drop_slot_o  (drop_slot_o),
  .drop_total_o (drop_total_o)
);

// File: tb/kc_concentrator_bench.sv
`timescale 1ns/1ps
module kc_concentrator_bench;
  localparam int N = 8, L = 2, W = 3, DW = 8, DROP_W = 4;
  localparam int CNT_W = $clog2(N + W + 1);
  localparam int TOPV = (1 << DROP_W) - 1;

  logic              clk = 0;
  logic              rst = 1;
  logic              slot_i = 0;
  logic [N-1:0]      in_valid_i = '0;
  logic [N*DW-1:0]   in_data_i = '0;
  logic [L-1:0]      out_valid_o;
  logic [L*DW-1:0]   out_data_o;
  logic              drop_pulse_o;
  logic [CNT_W-1:0]  drop_slot_o;
  logic [DROP_W-1:0] drop_total_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int wq[$];
  int m_total = 0;
  int e_v[L];
  int e_d[L];
  int e_pulse, e_cnt;

  always #4 clk = ~clk;

  kc_concentrator #(.N(N), .L(L), .W(W), .DW(DW), .DROP_W(DROP_W)) u_kc_concentrator (
    .clk(clk), .rst(rst), .slot_i(slot_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o), .drop_pulse_o(drop_pulse_o),
    .drop_slot_o(drop_slot_o), .drop_total_o(drop_total_o));

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    for (int k = 0; k < L; k++) begin
      chk(int'(out_valid_o[k]), e_v[k], req, $sformatf("lane %0d valid", k));
      if (e_v[k] == 1) chk(int'(out_data_o[k*DW +: DW]), e_d[k], req, $sformatf("lane %0d data", k));
    end
    chk(int'(drop_pulse_o), e_pulse, req, "drop pulse");
    chk(int'(drop_slot_o), e_cnt, req, "drop count");
    chk(int'(drop_total_o), m_total, req, "drop total");
  endtask

  // behavioural reference: queue of parked payloads, list of candidates
  task automatic model(bit slot, logic [N-1:0] v, logic [N*DW-1:0] d);
    int cd[$];
    int cw[$];
    int nq[$];
    int nwin = 0, drops = 0;
    for (int k = 0; k < L; k++) begin e_v[k] = 0; e_d[k] = 0; end
    e_pulse = 0; e_cnt = 0;
    if (!slot) return;
    foreach (wq[i]) begin cd.push_back(wq[i]); cw.push_back(1); end
    for (int p = 0; p < N; p++)
      if (v[p]) begin cd.push_back(int'(d[p*DW +: DW])); cw.push_back(0); end
    foreach (cd[i]) begin
      if (nwin < L) begin e_v[nwin] = 1; e_d[nwin] = cd[i]; nwin++; end
      else if (cw[i] == 0 && nq.size() < W) nq.push_back(cd[i]);
      else drops++;
    end
    wq = nq;
    e_pulse = (drops > 0);
    e_cnt = drops;
    m_total = (m_total + drops > TOPV) ? TOPV : m_total + drops;
  endtask

  task automatic step(bit slot, logic [N-1:0] v, logic [N*DW-1:0] d, string req);
    slot_i = slot; in_valid_i = v; in_data_i = d;
    model(slot, v, d);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [N*DW-1:0] pat(int base);
    logic [N*DW-1:0] r;
    for (int p = 0; p < N; p++) r[p*DW +: DW] = DW'(base + p);
    return r;
  endfunction

  task automatic do_reset();
    rst = 1; slot_i = 0; in_valid_i = '0;
    wq.delete(); m_total = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    while (!done && cycles < 20000) begin @(posedge clk); cycles++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8 reset state
    model(0, '0, '0);
    compare("R8");
    // R1 R3: one packet on port 5 goes to lane 0
    step(1, 8'b0010_0000, pat(8'h10), "R3");
    // R9: inputs with no strobe are ignored
    step(0, 8'hFF, pat(8'h20), "R9");
    step(0, 8'hFF, pat(8'h20), "R1");
    // R2 R4 R6: full load, ports 0,1 win, 2..4 parked, 5..7 dropped
    step(1, 8'hFF, pat(8'h30), "R4");
    // R10: parked packets survive idle cycles
    repeat (3) step(0, 8'h0F, pat(8'h40), "R10");
    // R5: parked 2,3 win, parked 4 dropped, new 0,7 parked
    step(1, 8'b1000_0001, pat(8'h50), "R5");
    // R3: only parked packets remain
    step(1, '0, '0, "R3");
    step(1, '0, '0, "R2");
    // R7: saturate the total
    repeat (4) step(1, 8'hFF, pat(8'h60), "R7");
    step(0, '0, '0, "R7");
    // R8: parked packets cleared by reset
    step(1, 8'hFF, pat(8'h70), "R4");
    do_reset();
    step(1, '0, '0, "R8");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [N*DW-1:0] rd;
      for (int p = 0; p < N; p++) rd[p*DW +: DW] = DW'($urandom_range(0, 255));
      step(bit'($urandom_range(0, 2) != 0), N'($urandom_range(0, 255)), rd,
           (i % 2 == 0) ? "R6" : "R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule